// File: doc/BRIEF.md
# Erased Sector Judge

When a NAND sector fails ECC decoding, it may be a page that was erased and never written. An erased page reads back as all ones, and its ECC bytes are all ones too. That pattern is not a valid codeword, so the decoder rejects it. This block takes the bytes of such a sector, one per cycle, in a fixed order. The first `DATA_BYTES` bytes are payload and every byte after them is stored ECC. The block counts the bits that read as zero, keeping one tally for the payload and another for the ECC. Each tally stops climbing at `LIMIT+1`.

One cycle after the byte marked last, the block gives its verdict with a single-cycle `done_o`. The sector is treated as erased when the two tallies add up to no more than `LIMIT`. Otherwise it is uncorrectable. For an erased sector whose payload held some zero bits, the block raises a request to overwrite the payload with ones, and it reports the payload tally as the number of corrected bits. The block does not rewrite any buffer itself. A `start_i` pulse before each sector clears both tallies and the byte position. Both tallies stay visible on the ports between sectors.

Top module: `erased_sector_judge`

## Requirements
- R1: After reset, `done_o`, `erased_o` and `fill_ones_o` are 0, and `corrected_o`, `data_zeros_o` and `ecc_zeros_o` are 0.
- R2: Each accepted byte adds its number of 0 bits to a tally. The bytes at positions 0 to `DATA_BYTES-1` after a start go to `data_zeros_o`.
- R3: Every accepted byte at position `DATA_BYTES` or later, counted from the start, goes to `ecc_zeros_o` and leaves `data_zeros_o` unchanged.
- R4: Each tally saturates at `LIMIT+1` (9 by default) and never wraps. Below that value it is exact.
- R5: In the cycle after a cycle with `start_i` high, both tallies read 0 and the byte position is back at 0. A byte offered together with `start_i` is dropped.
- R6: `done_o` is high for exactly the one cycle that follows each cycle where a byte is accepted with `in_last_i` high. It is low at all other times.
- R7: In the `done_o` cycle, `erased_o` is 1 if `data_zeros_o + ecc_zeros_o <= LIMIT` and 0 otherwise. A 0 there means the sector is uncorrectable.
- R8: In the `done_o` cycle, if the sector is erased and the payload tally is non-zero, then `fill_ones_o` is 1 and `corrected_o` equals the payload tally.
- R9: In the `done_o` cycle, if the sector is erased and the payload tally is 0, then `fill_ones_o` is 0 and `corrected_o` is 0. This holds even when the ECC tally is non-zero.
- R10: A cycle with `in_valid_i` low adds nothing to either tally and does not advance the byte position, whatever `in_byte_i` holds.
- R11: Outside a `done_o` cycle, `erased_o` and `fill_ones_o` are 0 and `corrected_o` is 0. For an uncorrectable sector they are also 0 in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears both tallies and the byte position |
| in_valid_i | input | 1 | `in_byte_i` carries a sector byte this cycle |
| in_byte_i | input | BYTE_W | Sector byte: payload first, then ECC |
| in_last_i | input | 1 | Marks the final byte of the sector |
| done_o | output | 1 | Verdict strobe, one cycle |
| erased_o | output | 1 | Sector is treated as erased (valid with `done_o`) |
| fill_ones_o | output | 1 | Request to overwrite the payload with ones |
| corrected_o | output | CNT_W | Number of bits reported as corrected |
| data_zeros_o | output | CNT_W | Current payload zero tally, saturating |
| ecc_zeros_o | output | CNT_W | Current ECC zero tally, saturating |

## Verification
If the byte position tracker is off by one, a zero bit in the last payload byte or the first ECC byte lands in the other tally. The mismatch shows on `data_zeros_o` and `ecc_zeros_o` in the `done_o` cycle of the sector that carried that byte. A tally that wraps instead of saturating turns a fully zero payload into a small count, and the verdict flips to erased in that same `done_o` cycle. A wrong limit comparison shows only when the sum lands exactly on `LIMIT` or `LIMIT+1`, so sectors are built at both of those sums. A bad clear on start shows one cycle after the pulse, as a non-zero tally.

// File: rtl/esj_pkg.sv
package esj_pkg;

  // Which tally a sector byte feeds
  typedef enum logic {
    SEG_DATA = 1'b0,
    SEG_ECC  = 1'b1
  } seg_e;

  localparam int NUM_SEGS = 2;

endpackage

// File: rtl/esj_seg_tracker.sv
module esj_seg_tracker #(
  parameter int DATA_BYTES = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         take_i,
  output esj_pkg::seg_e seg_o
);
  localparam int PW = $clog2(DATA_BYTES + 1);
  localparam logic [PW-1:0] PAYLOAD_END = PW'(DATA_BYTES);

  logic [PW-1:0] pos_q;
  logic          at_end;

  assign at_end = (pos_q == PAYLOAD_END);

  // Position stops at the payload boundary: everything after it is ECC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (clear_i) begin
      pos_q <= '0;
    end else if (take_i && !at_end) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign seg_o = at_end ? esj_pkg::SEG_ECC : esj_pkg::SEG_DATA;

endmodule

// File: rtl/esj_zero_tally.sv
module esj_zero_tally #(
  parameter int BYTE_W = 8,
  parameter int LIMIT  = 8,
  parameter int CNT_W  = $clog2(LIMIT + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  count_nxt_o
);
  localparam int CEIL = LIMIT + 1;

  // Number of bits that read as zero
  function automatic int unsigned zeros_of(input logic [BYTE_W-1:0] b);
    int unsigned n;
    n = 0;
    for (int i = 0; i < BYTE_W; i++) begin
      n += {31'd0, ~b[i]};
    end
    return n;
  endfunction

  // Sum clipped at CEIL, so the count is exact below it and never wraps
  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] cur,
                                               input int unsigned inc);
    int unsigned s;
    s = int'(cur) + inc;
    if (s > CEIL) s = CEIL;
    return CNT_W'(s);
  endfunction

  logic [CNT_W-1:0] count_q;

  always_comb begin
    if (clear_i)    count_nxt_o = '0;
    else if (add_i) count_nxt_o = sat_add(count_q, zeros_of(byte_i));
    else            count_nxt_o = count_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_nxt_o;
  end

  assign count_o = count_q;

endmodule

// File: rtl/esj_verdict.sv
module esj_verdict #(
  parameter int LIMIT = 8,
  parameter int CNT_W = $clog2(LIMIT + 2)
) (
  input  logic [CNT_W-1:0] data_cnt_i,
  input  logic [CNT_W-1:0] ecc_cnt_i,
  output logic             erased_o,
  output logic             fill_o,
  output logic [CNT_W-1:0] corrected_o
);
  function automatic logic [CNT_W:0] joint(input logic [CNT_W-1:0] a,
                                           input logic [CNT_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic within_reach(input logic [CNT_W:0] total);
    return int'(total) <= LIMIT;
  endfunction

  logic [CNT_W:0] total;

  assign total       = joint(data_cnt_i, ecc_cnt_i);
  assign erased_o    = within_reach(total);
  assign fill_o      = erased_o && (data_cnt_i != '0);
  assign corrected_o = erased_o ? data_cnt_i : '0;

endmodule

// File: rtl/erased_sector_judge.sv
module erased_sector_judge #(
  parameter int DATA_BYTES = 512,
  parameter int BYTE_W     = 8,
  parameter int LIMIT      = 8,
  parameter int CNT_W      = $clog2(LIMIT + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              in_last_i,
  output logic              done_o,
  output logic              erased_o,
  output logic              fill_ones_o,
  output logic [CNT_W-1:0]  corrected_o,
  output logic [CNT_W-1:0]  data_zeros_o,
  output logic [CNT_W-1:0]  ecc_zeros_o
);
  import esj_pkg::*;

  // Named internal events
  logic             byte_take;
  logic             sector_end;
  seg_e             seg;
  logic [CNT_W-1:0] tally_q   [NUM_SEGS];
  logic [CNT_W-1:0] tally_nxt [NUM_SEGS];
  logic             v_erased;
  logic             v_fill;
  logic [CNT_W-1:0] v_corrected;

  assign byte_take  = in_valid_i && !start_i;
  assign sector_end = byte_take && in_last_i;

  esj_seg_tracker #(.DATA_BYTES(DATA_BYTES)) seg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .take_i  (byte_take),
    .seg_o   (seg)
  );

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_tally
    logic add;
    assign add = byte_take && (int'(seg) == g);
    esj_zero_tally #(.BYTE_W(BYTE_W), .LIMIT(LIMIT), .CNT_W(CNT_W)) tally_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (start_i),
      .add_i       (add),
      .byte_i      (in_byte_i),
      .count_o     (tally_q[g]),
      .count_nxt_o (tally_nxt[g])
    );
  end

  // Judge the counts that include the final byte
  esj_verdict #(.LIMIT(LIMIT), .CNT_W(CNT_W)) verdict_i (
    .data_cnt_i  (tally_nxt[SEG_DATA]),
    .ecc_cnt_i   (tally_nxt[SEG_ECC]),
    .erased_o    (v_erased),
    .fill_o      (v_fill),
    .corrected_o (v_corrected)
  );

  logic             done_q;
  logic             erased_q;
  logic             fill_q;
  logic [CNT_W-1:0] corrected_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      erased_q    <= 1'b0;
      fill_q      <= 1'b0;
      corrected_q <= '0;
    end else begin
      done_q      <= sector_end;
      erased_q    <= sector_end && v_erased;
      fill_q      <= sector_end && v_fill;
      corrected_q <= sector_end ? v_corrected : '0;
    end
  end

  assign done_o       = done_q;
  assign erased_o     = erased_q;
  assign fill_ones_o  = fill_q;
  assign corrected_o  = corrected_q;
  assign data_zeros_o = tally_q[SEG_DATA];
  assign ecc_zeros_o  = tally_q[SEG_ECC];

endmodule

// File: rtl/esj_checker.sv
module esj_checker #(
  parameter int LIMIT = 8,
  parameter int CNT_W = $clog2(LIMIT + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             in_valid_i,
  input logic             in_last_i,
  input logic             byte_take,
  input logic             done_o,
  input logic             erased_o,
  input logic             fill_ones_o,
  input logic [CNT_W-1:0] corrected_o,
  input logic [CNT_W-1:0] data_zeros_o,
  input logic [CNT_W-1:0] ecc_zeros_o
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, data_zeros_o} + {1'b0, ecc_zeros_o};

  // R6
  done_follows_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_take && in_last_i) |=> done_o);

  // R6
  done_only_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_take && in_last_i) |=> !done_o);

  // R4
  tally_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(data_zeros_o) <= LIMIT + 1) && (int'(ecc_zeros_o) <= LIMIT + 1));

  // R5
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (data_zeros_o == '0) && (ecc_zeros_o == '0));

  // R10
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !start_i) |=> ($stable(data_zeros_o) && $stable(ecc_zeros_o)));

  // R7
  erased_within_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && erased_o) |-> (int'(sum) <= LIMIT));

  // R7
  uncorrectable_beyond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !erased_o) |-> (int'(sum) > LIMIT));

  // R8
  fill_consistent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ones_o |-> (erased_o && (corrected_o == data_zeros_o) && (data_zeros_o != '0)));

  // R11
  quiet_outside_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!erased_o && !fill_ones_o && (corrected_o == '0)));

endmodule

bind erased_sector_judge esj_checker #(.LIMIT(LIMIT), .CNT_W(CNT_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .in_valid_i   (in_valid_i),
  .in_last_i    (in_last_i),
  .byte_take    (byte_take),
  .done_o       (done_o),
  .erased_o     (erased_o),
  .fill_ones_o  (fill_ones_o),
  .corrected_o  (corrected_o),
  .data_zeros_o (data_zeros_o),
  .ecc_zeros_o  (ecc_zeros_o)
);

// File: tb/erased_sector_judge_tb_top.sv
module erased_sector_judge_tb_top;
  localparam int DATA_BYTES = 512;
  localparam int ECC_BYTES  = 13;
  localparam int LIMIT      = 8;
  localparam int CNT_W      = $clog2(LIMIT + 2);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             valid = 1'b0;
  logic [7:0]       bytev = 8'h00;
  logic             last = 1'b0;
  logic             done, erased, fill;
  logic [CNT_W-1:0] corrected, dz, ez;

  always #2 clk = ~clk;  // 250 MHz

  erased_sector_judge #(.DATA_BYTES(DATA_BYTES), .BYTE_W(8), .LIMIT(LIMIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_valid_i(valid),
    .in_byte_i(bytev), .in_last_i(last), .done_o(done), .erased_o(erased),
    .fill_ones_o(fill), .corrected_o(corrected), .data_zeros_o(dz), .ecc_zeros_o(ez)
  );

  typedef struct packed {
    logic        erased;
    logic        fill;
    logic [7:0]  corrected;
    logic [7:0]  dz;
    logic [7:0]  ez;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;

  task automatic check(string req, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Zero bits counted by clearing the lowest set bit of the inverted byte
  function automatic int zero_bits(input logic [7:0] b);
    logic [7:0] x;
    int n;
    x = ~b;
    n = 0;
    while (x != 0) begin
      x = x & (x - 1);
      n++;
    end
    return n;
  endfunction

  // Sector contents, chosen by pattern number
  function automatic logic [7:0] gen_byte(input int pat, input int idx);
    case (pat)
      1: return (idx == 5) ? 8'hF8 : (idx == 515) ? 8'hBD : 8'hFF;
      2: return (idx < 512 && idx % 64 == 0) ? 8'hFE : 8'hFF;
      3: return (idx == 10) ? 8'h07 : (idx == 520) ? 8'hF0 : 8'hFF;
      4: return (idx < 512) ? 8'h00 : 8'hFF;
      5: return (idx == 512) ? 8'h00 : 8'hFF;
      6: return (idx == 512) ? 8'h00 : (idx == 524) ? 8'h7F : 8'hFF;
      7: return (idx == 511) ? 8'h7F : (idx == 512) ? 8'hFC : 8'hFF;
      8: return (idx == 3) ? 8'hEF : (idx >= 512) ? 8'h00 : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic run_sector(input int pat, input bit gaps);
    int   d, e;
    exp_t x;
    d = 0;
    e = 0;
    for (int i = 0; i < DATA_BYTES + ECC_BYTES; i++) begin
      if (i < DATA_BYTES) d += zero_bits(gen_byte(pat, i));
      else                e += zero_bits(gen_byte(pat, i));
    end
    if (d > LIMIT + 1) d = LIMIT + 1;
    if (e > LIMIT + 1) e = LIMIT + 1;
    x.erased    = (d + e) <= LIMIT;
    x.fill      = x.erased && d != 0;
    x.corrected = x.erased ? 8'(d) : 8'd0;
    x.dz        = 8'(d);
    x.ez        = 8'(e);
    exp_q.push_back(x);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < DATA_BYTES + ECC_BYTES; i++) begin
      if (gaps && i % 37 == 0) begin
        valid = 1'b0;  // R10: junk on an idle cycle
        bytev = 8'h00;
        last  = 1'b0;
        @(negedge clk);
      end
      valid = 1'b1;
      bytev = gen_byte(pat, i);
      last  = (i == DATA_BYTES + ECC_BYTES - 1);
      @(negedge clk);
    end
    valid = 1'b0;
    last  = 1'b0;
    bytev = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop and compare on every verdict
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R6", "unexpected done", 1, 0);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        check("R7", "erased", int'(erased), int'(x.erased));
        check("R8", "fill", int'(fill), int'(x.fill));
        check("R9", "corrected", int'(corrected), int'(x.corrected));
        check("R2", "data zeros", int'(dz), int'(x.dz));
        check("R3", "ecc zeros", int'(ez), int'(x.ez));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done", int'(done), 0);
    check("R1", "erased", int'(erased), 0);
    check("R1", "corrected", int'(corrected), 0);
    check("R1", "zeros", int'(dz) + int'(ez), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: partial stream of zero bytes saturates the payload tally
    for (int i = 0; i < 4; i++) begin
      valid = 1'b1;
      bytev = 8'h00;
      @(negedge clk);
    end
    check("R4", "saturated data zeros", int'(dz), LIMIT + 1);
    // R5: start with a byte offered at the same time drops the byte
    start = 1'b1;
    valid = 1'b1;
    bytev = 8'h00;
    @(negedge clk);
    start = 1'b0;
    valid = 1'b0;
    check("R5", "data zeros after start", int'(dz), 0);
    check("R5", "ecc zeros after start", int'(ez), 0);
    // R10: idle cycles with zero bytes change nothing
    bytev = 8'h00;
    repeat (4) @(negedge clk);
    check("R10", "idle data zeros", int'(dz), 0);
    check("R11", "no verdict while idle", int'(done) + int'(fill) + int'(erased), 0);

    run_sector(0, 1'b0);  // R9 clean erased
    run_sector(1, 1'b1);  // R8 few flips
    run_sector(2, 1'b0);  // R7 sum exactly at limit
    run_sector(3, 1'b1);  // R7 sum one past limit
    run_sector(4, 1'b0);  // R4 payload saturates
    run_sector(5, 1'b0);  // R9 erased, ECC flips only
    run_sector(6, 1'b1);  // R3 ECC alone exceeds limit
    run_sector(7, 1'b0);  // R3 payload/ECC boundary
    run_sector(8, 1'b0);  // R4 ECC saturates

    repeat (5) @(negedge clk);
    check("R6", "verdicts outstanding", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule